// File: doc/BRIEF.md
# Level Crossing Gate Controller

This block drives a level-crossing barrier from single-cycle train arrival and departure pulses. It counts the trains inside the protected zone. The first arrival into an empty zone produces a one-cycle close request. A one-cycle open request is produced only when a departure takes the count back to zero. Departures that would take the count below zero are rejected and remembered in a sticky sequencing error flag.

Alongside the counter, the block tracks the barrier mechanism as a four-state model. The model moves on its own commands and on the two end-of-travel feedback inputs. A deadline monitor counts tick strobes after each close request. It raises a sticky fault when the barrier has not come down within the allowed number of ticks. An open request issued before the deadline cancels that watch. The host supplies clean, already debounced pulses. The motor drive is handled elsewhere.

Top module: `crossing_gate_ctrl`

## Requirements
- R1: After synchronous reset the zone is empty, `gate_state` reads 0 (Closed), and `close_cmd`, `open_cmd`, `deadline_fault` and `seq_error` are all low.
- R2: An arrival pulse while the zone is empty makes `close_cmd` high for exactly one cycle, in the cycle after the pulse. Further arrivals issue no command.
- R3: A departure pulse that brings the count from one to zero makes `open_cmd` high for exactly one cycle, in the cycle after the pulse. No other departure issues a command.
- R4: Arrival and departure pulses in the same cycle leave the count unchanged and issue no command.
- R5: A departure pulse while the count is zero leaves the count at zero and issues no command. It sets `seq_error`, which stays high until reset.
- R6: The count saturates at 2^CNT_W-1. Further arrivals at that value leave the count unchanged, so exactly that many departures are then needed to produce `open_cmd`.
- R7: `gate_state` uses the encoding Closed=0, Opening=1, Open=2, Closing=3 and changes one cycle after its cause. An open command moves Closed to Opening. Open feedback moves Opening to Open. A close command moves Opening or Open to Closing. Closed feedback moves Closing to Closed. A close command while the state is Closed has no effect.
- R8: An open command while the state is Closing moves it to Opening. Closed feedback outside Closing and open feedback outside Opening have no effect.
- R9: After a close command, `deadline_fault` rises one cycle after the DEADLINE_TICKS-th tick if `gate_state` has not returned to Closed before that tick. If the state returns to Closed earlier, the fault stays low.
- R10: An open command issued before the deadline expires cancels the watch, so later ticks raise no fault.
- R11: `deadline_fault` stays high once set until reset, whatever the feedback and tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_enter | input | 1 | One-cycle pulse: a train entered the zone |
| train_leave | input | 1 | One-cycle pulse: a train left the zone |
| gate_open_fb | input | 1 | Barrier reached its fully open position |
| gate_closed_fb | input | 1 | Barrier reached its fully closed position |
| tick | input | 1 | Time-base strobe for the close deadline |
| close_cmd | output | 1 | One-cycle request to lower the barrier |
| open_cmd | output | 1 | One-cycle request to raise the barrier |
| gate_state | output | 2 | Barrier model state (0 Closed, 1 Opening, 2 Open, 3 Closing) |
| deadline_fault | output | 1 | Sticky: barrier missed its close deadline |
| seq_error | output | 1 | Sticky: departure seen with the zone empty |

## Verification
The hardest case to reach from the ports is a deadline that is cancelled. The deadline can only be armed usefully when the barrier is up. So the stimulus first takes the controller through a full arrival, departure and open feedback cycle. It then sends a fresh arrival, supplies fewer ticks than the limit, and sends a departure so that the open request lands before expiry. Ticks continue after that, to show that no fault appears. The separate expiry case, and its stickiness, are exercised last, because only a reset clears the fault.

// File: rtl/gxc_pkg.sv
package gxc_pkg;
  typedef enum logic [1:0] {
    GS_CLOSED  = 2'd0,
    GS_OPENING = 2'd1,
    GS_OPEN    = 2'd2,
    GS_CLOSING = 2'd3
  } gate_state_t;
endpackage

// File: rtl/gxc_occupancy.sv
module gxc_occupancy #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic leave,
  output logic cmd_close,
  output logic cmd_open,
  output logic seq_err
);
  localparam logic [CNT_W-1:0] OCC_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] OCC_ONE = CNT_W'(1);

  logic [CNT_W-1:0] occ;
  logic             arrive_only;
  logic             depart_only;

  assign arrive_only = enter && !leave;
  assign depart_only = leave && !enter;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ       <= '0;
      cmd_close <= 1'b0;
      cmd_open  <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      cmd_close <= 1'b0;
      cmd_open  <= 1'b0;
      if (arrive_only) begin
        if (occ == '0) cmd_close <= 1'b1;
        if (occ != OCC_MAX) occ <= occ + OCC_ONE;
      end else if (depart_only) begin
        if (occ == '0) begin
          seq_err <= 1'b1;
        end else begin
          occ <= occ - OCC_ONE;
          if (occ == OCC_ONE) cmd_open <= 1'b1;
        end
      end
    end
  end

  // R2
  close_first_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_close |-> occ == OCC_ONE);

  // R3
  open_empty_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_open |-> occ == '0);

  // R4
  cancel_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (enter && leave) |=> ($stable(occ) && !cmd_close && !cmd_open));

  // R5
  seq_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_MAX && arrive_only) |=> occ == OCC_MAX);
endmodule

// File: rtl/gxc_gate_model.sv
module gxc_gate_model
  import gxc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_open,
  input  logic        cmd_close,
  input  logic        fb_open,
  input  logic        fb_closed,
  output gate_state_t st
);
  gate_state_t st_nxt;

  always_comb begin
    st_nxt = st;
    case (st)
      GS_CLOSED:  if (cmd_open) st_nxt = GS_OPENING;
      GS_OPENING: if (cmd_close) st_nxt = GS_CLOSING;
                  else if (fb_open) st_nxt = GS_OPEN;
      GS_OPEN:    if (cmd_close) st_nxt = GS_CLOSING;
      GS_CLOSING: if (cmd_open) st_nxt = GS_OPENING;
                  else if (fb_closed) st_nxt = GS_CLOSED;
      default:    st_nxt = GS_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= GS_CLOSED;
    else     st <= st_nxt;
  end

  // R7
  open_via_opening_chk: assert property (@(posedge clk) disable iff (rst)
    (st == GS_OPEN && $past(st) != GS_OPEN) |-> $past(st) == GS_OPENING);

  // R8
  closed_via_closing_chk: assert property (@(posedge clk) disable iff (rst)
    (st == GS_CLOSED && $past(st) != GS_CLOSED) |-> $past(st) == GS_CLOSING);
endmodule

// File: rtl/gxc_deadline.sv
module gxc_deadline
  import gxc_pkg::*;
#(
  parameter int LIMIT = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_close,
  input  logic        cmd_open,
  input  logic        tick,
  input  gate_state_t gate_st,
  output logic        fault
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      fault <= 1'b0;
    end else if (cmd_close) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed) begin
      if (gate_st == GS_CLOSED || cmd_open) begin
        armed <= 1'b0;
      end else if (tick) begin
        if (cnt == LAST) begin
          fault <= 1'b1;
          armed <= 1'b0;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end

  // R9
  fault_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> ($past(tick) && $past(gate_st) != GS_CLOSED));

  // R10
  open_cancels_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_open |=> !$rose(fault));

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);
endmodule

// File: rtl/crossing_gate_ctrl.sv
module crossing_gate_ctrl
  import gxc_pkg::*;
#(
  parameter int CNT_W          = 2,
  parameter int DEADLINE_TICKS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       train_enter,
  input  logic       train_leave,
  input  logic       gate_open_fb,
  input  logic       gate_closed_fb,
  input  logic       tick,
  output logic       close_cmd,
  output logic       open_cmd,
  output logic [1:0] gate_state,
  output logic       deadline_fault,
  output logic       seq_error
);
  gate_state_t st;

  gxc_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk       (clk),
    .rst       (rst),
    .enter     (train_enter),
    .leave     (train_leave),
    .cmd_close (close_cmd),
    .cmd_open  (open_cmd),
    .seq_err   (seq_error)
  );

  gxc_gate_model u_gate (
    .clk       (clk),
    .rst       (rst),
    .cmd_open  (open_cmd),
    .cmd_close (close_cmd),
    .fb_open   (gate_open_fb),
    .fb_closed (gate_closed_fb),
    .st        (st)
  );

  gxc_deadline #(.LIMIT(DEADLINE_TICKS)) u_dl (
    .clk       (clk),
    .rst       (rst),
    .cmd_close (close_cmd),
    .cmd_open  (open_cmd),
    .tick      (tick),
    .gate_st   (st),
    .fault     (deadline_fault)
  );

  assign gate_state = st;

  // R1
  cmds_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(close_cmd && open_cmd));
endmodule

// File: tb/crossing_gate_ctrl_bench.sv
module crossing_gate_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic train_enter = 1'b0, train_leave = 1'b0;
  logic gate_open_fb = 1'b0, gate_closed_fb = 1'b0, tick = 1'b0;
  logic close_cmd, open_cmd, deadline_fault, seq_error;
  logic [1:0] gate_state;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  byte exp_q[$];

  crossing_gate_ctrl u_crossing_gate_ctrl (
    .clk(clk), .rst(rst), .train_enter(train_enter), .train_leave(train_leave),
    .gate_open_fb(gate_open_fb), .gate_closed_fb(gate_closed_fb), .tick(tick),
    .close_cmd(close_cmd), .open_cmd(open_cmd), .gate_state(gate_state),
    .deadline_fault(deadline_fault), .seq_error(seq_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 enter, 1 leave, 2 open feedback, 3 closed feedback, 4 tick
  task automatic pulse(int which);
    case (which)
      0: train_enter = 1'b1;
      1: train_leave = 1'b1;
      2: gate_open_fb = 1'b1;
      3: gate_closed_fb = 1'b1;
      default: tick = 1'b1;
    endcase
    step(1);
    train_enter = 1'b0; train_leave = 1'b0;
    gate_open_fb = 1'b0; gate_closed_fb = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      pulse(4);
      step(1);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: pops expected commands as the design produces them
  always @(negedge clk) begin : mon
    byte got;
    byte want;
    if (!rst && (close_cmd || open_cmd)) begin
      got = close_cmd ? "C" : "O";
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 command actual %c expected none", got);
      end else begin
        want = exp_q.pop_front();
        chk("R2 R3 command kind", int'(got), int'(want));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 gate_state", gate_state, 0);
    chk("R1 close_cmd", close_cmd, 0);
    chk("R1 open_cmd", open_cmd, 0);
    chk("R1 fault", deadline_fault, 0);
    chk("R1 seq_error", seq_error, 0);

    // R5: departure with empty zone
    pulse(1);
    chk("R5 seq_error set", seq_error, 1);
    step(3);
    chk("R5 seq_error sticky", seq_error, 1);

    // R2: first arrival closes; gate already Closed stays Closed (R7)
    exp_q.push_back("C");
    pulse(0);
    chk("R2 close pulse", close_cmd, 1);
    step(1);
    chk("R2 close is one cycle", close_cmd, 0);
    chk("R7 close in Closed ignored", gate_state, 0);

    // R6: fill to 3 then one more saturates; R4: simultaneous pair
    pulse(0); pulse(0); pulse(0);
    train_enter = 1'b1; train_leave = 1'b1;
    step(1);
    train_enter = 1'b0; train_leave = 1'b0;
    pulse(1); pulse(1);
    chk("R6 no open before last departure", open_cmd, 0);
    exp_q.push_back("O");
    pulse(1);
    chk("R3 R6 open after third departure", open_cmd, 1);
    step(1);
    chk("R3 open is one cycle", open_cmd, 0);
    chk("R7 Opening", gate_state, 1);

    // R8: closed feedback ignored outside Closing
    pulse(3); step(1);
    chk("R8 closed fb ignored in Opening", gate_state, 1);
    pulse(2); step(1);
    chk("R7 Open", gate_state, 2);
    pulse(2); step(1);
    chk("R8 open fb ignored in Open", gate_state, 2);

    // R10: cancel deadline with an open request
    exp_q.push_back("C");
    pulse(0);
    step(1);
    chk("R7 Closing", gate_state, 3);
    ticks(3);
    exp_q.push_back("O");
    pulse(1);
    step(1);
    chk("R8 reversal to Opening", gate_state, 1);
    ticks(7);
    chk("R10 no fault after cancel", deadline_fault, 0);
    pulse(2); step(1);
    chk("R7 Open again", gate_state, 2);

    // R9: closed in time, no fault
    exp_q.push_back("C");
    pulse(0);
    step(1);
    ticks(4);
    pulse(3); step(1);
    chk("R7 Closed via feedback", gate_state, 0);
    ticks(4);
    chk("R9 no fault when closed in time", deadline_fault, 0);
    exp_q.push_back("O");
    pulse(1); step(1);
    pulse(2); step(1);
    chk("R7 Open third time", gate_state, 2);

    // R9: expiry
    exp_q.push_back("C");
    pulse(0);
    step(1);
    ticks(4);
    chk("R9 no fault after four ticks", deadline_fault, 0);
    pulse(4);
    chk("R9 fault after fifth tick", deadline_fault, 1);
    step(1);

    // R11: sticky
    pulse(3); step(1);
    chk("R11 gate closes late", gate_state, 0);
    ticks(3);
    chk("R11 fault sticky", deadline_fault, 1);

    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R11 reset clears fault", deadline_fault, 0);
    chk("R1 reset clears seq_error", seq_error, 0);
    chk("R1 reset gate Closed", gate_state, 0);

    step(3);
    chk("R3 all expected commands seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule